// File: doc/BRIEF.md
# Hall Sensor Debounce and Six-Step Commutator

This block turns the three Hall sensor lines of a brushless motor into gate commands for a three-phase bridge. On each pulse of a periodic sampling tick it reads the sensors as one 3-bit code. A change in that code is accepted only after the new value has been seen on enough consecutive ticks. Each accepted code selects one of six commutation states. Each state turns on one high-side switch, which follows the incoming PWM signal, and one low-side switch, which is held fully on. All other switches stay off.

A stall watchdog counts sampling ticks on which the accepted code does not change. If no edge arrives for a full counter span, it raises the same one-cycle commutation trigger that an accepted edge raises. This lets the surrounding controller restart rotation. The PWM carrier and any speed or current loop are outside this block. The debounce threshold comes from a port that is normally tied to 10.

Top module: `hall_commutator`

## Requirements
- R1: The sensor code is {hallA, hallB, hallC}: A is bit 2, B is bit 1 and C is bit 0.
- R2: After a synchronous reset, all six gate outputs are low, the trigger and error flag are low and the edge count is zero. The gates stay low until the first tick resolves a valid state.
- R3: The first tick after reset loads both the accepted code and the candidate buffer from the sensors. It resolves the commutation state from that code, raises no trigger and leaves the edge count at zero.
- R4: With threshold L, a new code held steady is accepted on its (L+2)th consecutive tick. Clock cycles without a tick do not advance the debounce.
- R5: A tick whose sample equals the accepted code clears the debounce count but keeps the buffer. A sample that differs from the buffer replaces the buffer and clears the count.
- R6: Each acceptance raises commTrig for exactly one clock cycle and adds one to edgeCount.
- R7: Accepted codes select these states: 5 gives 0, 1 gives 1, 3 gives 2, 2 gives 3, 6 gives 4, 4 gives 5.
- R8: Gate bits are indexed with phase A at bit 0, B at bit 1 and C at bit 2. The state pairs are: 0 = A high with C low, 1 = B high with C low, 2 = C high with B low, 3 = A high with B low, 4 = B high with A low, 5 = C high with A low. The high-side output equals pwmIn and the low-side output is steady high.
- R9: An accepted code of 0 or 7 leaves the state and gates unchanged and sets hallError. The next accepted valid code clears hallError. The invalid edge still counts and still triggers.
- R10: The stall counter starts at all ones (2^STALL_W - 1). Each tick whose sample equals the accepted code decrements it. On the decrement that would reach zero, it pulses commTrig without counting an edge and reloads. Every accepted edge also reloads it.
- R11: The gate outputs (apart from PWM following) change only when the commutation state changes. A stall trigger leaves them untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Sampling strobe, one cycle per sample |
| hallA | input | 1 | Hall sensor A (code bit 2) |
| hallB | input | 1 | Hall sensor B (code bit 1) |
| hallC | input | 1 | Hall sensor C (code bit 0) |
| pwmIn | input | 1 | PWM applied to the active high-side switch |
| debounceLimit | input | DB_W | Debounce threshold L |
| gateHigh | output | 3 | High-side switch commands, bit 0 = A |
| gateLow | output | 3 | Low-side switch commands, bit 0 = A |
| commState | output | 3 | Current commutation state 0..5 |
| commTrig | output | 1 | One-cycle commutation trigger |
| hallError | output | 1 | Last accepted code was 0 or 7 |
| edgeCount | output | EDGE_W | Running count of accepted edges |

## Verification
The bench builds the block with STALL_W = 6, so the stall span is 63 quiet ticks. This puts two full stall expiries, and a reload by an edge in the middle of a span, within a short run. DB_W = 4 with a threshold of 3 keeps each acceptance to five ticks, which leaves room for glitch, restart and invalid-code sequences. EDGE_W = 8 is wide enough that every accepted edge shows up as a distinct count.

// File: rtl/hall_comm_pkg.sv
package hall_comm_pkg;

  typedef struct packed {
    logic       load;
    logic [2:0] code;
  } hallStrobe_t;

  typedef struct packed {
    logic       valid;
    logic [2:0] state;
  } hallDecode_t;

  typedef struct packed {
    logic [2:0] lowSel;
    logic [2:0] highSel;
  } switchSel_t;

  function automatic hallDecode_t decodeHall(input logic [2:0] code);
    hallDecode_t d;
    d.valid = 1'b1;
    case (code)
      3'd5:    d.state = 3'd0;
      3'd1:    d.state = 3'd1;
      3'd3:    d.state = 3'd2;
      3'd2:    d.state = 3'd3;
      3'd6:    d.state = 3'd4;
      3'd4:    d.state = 3'd5;
      default: begin d.state = 3'd0; d.valid = 1'b0; end
    endcase
    return d;
  endfunction

  // bit 0 = phase A, bit 1 = phase B, bit 2 = phase C
  function automatic switchSel_t stateSwitches(input logic [2:0] st);
    switchSel_t s;
    case (st)
      3'd0:    begin s.highSel = 3'b001; s.lowSel = 3'b100; end
      3'd1:    begin s.highSel = 3'b010; s.lowSel = 3'b100; end
      3'd2:    begin s.highSel = 3'b100; s.lowSel = 3'b010; end
      3'd3:    begin s.highSel = 3'b001; s.lowSel = 3'b010; end
      3'd4:    begin s.highSel = 3'b010; s.lowSel = 3'b001; end
      3'd5:    begin s.highSel = 3'b100; s.lowSel = 3'b001; end
      default: begin s.highSel = 3'b000; s.lowSel = 3'b000; end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/hall_ctrl.sv
module hall_ctrl
  import hall_comm_pkg::*;
#(
  parameter int DB_W    = 8,
  parameter int STALL_W = 16,
  parameter int EDGE_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [2:0]        hallCode,
  input  logic [DB_W-1:0]   debounceLimit,
  output hallStrobe_t       strobe,
  output logic              commTrig,
  output logic [EDGE_W-1:0] edgeCount
);

  localparam logic [STALL_W-1:0] STALL_MAX = {STALL_W{1'b1}};
  localparam logic [STALL_W-1:0] STALL_ONE = STALL_W'(1);

  logic               primed;
  logic [2:0]         acceptedCode;
  logic [2:0]         bufferCode;
  logic [DB_W-1:0]    dbCount;
  logic [STALL_W-1:0] stallCnt;

  logic sameAsAccepted;
  logic sameAsBuffer;
  logic acceptNow;
  logic stallHit;

  always_comb begin
    sameAsAccepted = (hallCode == acceptedCode);
    sameAsBuffer   = (hallCode == bufferCode);
    acceptNow      = tick && primed && !sameAsAccepted && sameAsBuffer
                     && (dbCount >= debounceLimit);
    stallHit       = tick && primed && sameAsAccepted && (stallCnt == STALL_ONE);
    strobe.load    = tick && (!primed || acceptNow);
    strobe.code    = hallCode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed       <= 1'b0;
      acceptedCode <= 3'd0;
      bufferCode   <= 3'd0;
      dbCount      <= '0;
      stallCnt     <= STALL_MAX;
      commTrig     <= 1'b0;
      edgeCount    <= '0;
    end else begin
      commTrig <= acceptNow || stallHit;
      if (tick) begin
        if (!primed) begin
          primed       <= 1'b1;
          acceptedCode <= hallCode;
          bufferCode   <= hallCode;
        end else if (sameAsAccepted) begin
          dbCount  <= '0;
          stallCnt <= stallHit ? STALL_MAX : stallCnt - STALL_ONE;
        end else if (sameAsBuffer) begin
          if (acceptNow) begin
            acceptedCode <= hallCode;
            dbCount      <= '0;
            stallCnt     <= STALL_MAX;
            edgeCount    <= edgeCount + EDGE_W'(1);
          end else begin
            dbCount <= dbCount + DB_W'(1);
          end
        end else begin
          bufferCode <= hallCode;
          dbCount    <= '0;
        end
      end
    end
  end

  AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (rst)
    commTrig |=> !commTrig); // R6

  AST_EDGE_STEP: assert property (@(posedge clk) disable iff (rst)
    (edgeCount != $past(edgeCount)) |-> (edgeCount == $past(edgeCount) + EDGE_W'(1))); // R6

  AST_EDGE_TRIGGERS: assert property (@(posedge clk) disable iff (rst)
    (edgeCount != $past(edgeCount)) |-> commTrig); // R6

  AST_INIT_SILENT: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && !primed) |=> (!commTrig && $stable(edgeCount))); // R3

endmodule

// File: rtl/hall_datapath.sv
module hall_datapath
  import hall_comm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  hallStrobe_t strobe,
  input  logic        pwmIn,
  output logic [2:0]  commState,
  output logic        hallError,
  output logic [2:0]  gateHigh,
  output logic [2:0]  gateLow
);

  hallDecode_t decoded;
  switchSel_t  nextSel;
  logic        stateValid;
  logic [2:0]  selHigh;
  logic [2:0]  selLow;

  always_comb begin
    decoded = decodeHall(strobe.code);
    nextSel = stateSwitches(decoded.state);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      commState  <= 3'd0;
      stateValid <= 1'b0;
      hallError  <= 1'b0;
      selHigh    <= 3'b000;
      selLow     <= 3'b000;
    end else if (strobe.load) begin
      if (decoded.valid) begin
        hallError <= 1'b0;
        if (!stateValid || (decoded.state != commState)) begin
          commState  <= decoded.state;
          stateValid <= 1'b1;
          selHigh    <= nextSel.highSel;
          selLow     <= nextSel.lowSel;
        end
      end else begin
        hallError <= 1'b1;
      end
    end
  end

  for (genvar ph = 0; ph < 3; ph++) begin : g_phase
    assign gateHigh[ph] = selHigh[ph] & pwmIn;
    assign gateLow[ph]  = selLow[ph];
  end

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> ($stable(selHigh) && $stable(selLow))); // R11

  AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    stateValid |-> ($onehot0(selHigh) && $countones(selLow) == 1 && (selHigh & selLow) == 3'b000)); // R8

  AST_INVALID_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && !decoded.valid) |=> ($stable(commState) && $stable(selLow) && hallError)); // R9

  AST_OFF_UNTIL_VALID: assert property (@(posedge clk) disable iff (rst)
    !stateValid |-> (gateHigh == 3'b000 && gateLow == 3'b000)); // R2

endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hall_comm_pkg::*;
#(
  parameter int DB_W    = 8,
  parameter int STALL_W = 16,
  parameter int EDGE_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              hallA,
  input  logic              hallB,
  input  logic              hallC,
  input  logic              pwmIn,
  input  logic [DB_W-1:0]   debounceLimit,
  output logic [2:0]        gateHigh,
  output logic [2:0]        gateLow,
  output logic [2:0]        commState,
  output logic              commTrig,
  output logic              hallError,
  output logic [EDGE_W-1:0] edgeCount
);

  logic [2:0]  hallCode;
  hallStrobe_t strobe;

  assign hallCode = {hallA, hallB, hallC};

  hall_ctrl #(
    .DB_W    (DB_W),
    .STALL_W (STALL_W),
    .EDGE_W  (EDGE_W)
  ) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .hallCode      (hallCode),
    .debounceLimit (debounceLimit),
    .strobe        (strobe),
    .commTrig      (commTrig),
    .edgeCount     (edgeCount)
  );

  hall_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .pwmIn     (pwmIn),
    .commState (commState),
    .hallError (hallError),
    .gateHigh  (gateHigh),
    .gateLow   (gateLow)
  );

endmodule

// File: tb/tb_hall_commutator.sv
module tb_hall_commutator;

  localparam int DB_W    = 4;
  localparam int STALL_W = 6;
  localparam int EDGE_W  = 8;
  localparam int LIMIT   = 3;
  localparam int STALL_SPAN = (1 << STALL_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick = 1'b0;
  logic              hallA = 1'b1, hallB = 1'b0, hallC = 1'b1;
  logic              pwmIn = 1'b1;
  logic [DB_W-1:0]   debounceLimit = DB_W'(LIMIT);
  logic [2:0]        gateHigh, gateLow, commState;
  logic              commTrig, hallError;
  logic [EDGE_W-1:0] edgeCount;

  int checks = 0;
  int fails  = 0;
  int expEdge = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hall_commutator #(.DB_W(DB_W), .STALL_W(STALL_W), .EDGE_W(EDGE_W)) dut (
    .clk(clk), .rst(rst), .tick(tick), .hallA(hallA), .hallB(hallB), .hallC(hallC),
    .pwmIn(pwmIn), .debounceLimit(debounceLimit), .gateHigh(gateHigh), .gateLow(gateLow),
    .commState(commState), .commTrig(commTrig), .hallError(hallError), .edgeCount(edgeCount)
  );

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Independent model of the code -> state -> switch tables
  function automatic int expState(input int code);
    case (code)
      5: return 0; 1: return 1; 3: return 2;
      2: return 3; 6: return 4; 4: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic int expHigh(input int st);
    case (st)
      0, 3: return 1; 1, 4: return 2; default: return 4;
    endcase
  endfunction

  function automatic int expLow(input int st);
    case (st)
      0, 1: return 4; 2, 3: return 2; default: return 1;
    endcase
  endfunction

  task automatic setHall(input int code);
    @(negedge clk);
    hallA = code[2]; hallB = code[1]; hallC = code[0];
  endtask

  task automatic pulseTick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) pulseTick();
  endtask

  task automatic acceptCode(input int code);
    setHall(code);
    ticks(LIMIT + 2);
    expEdge++;
  endtask

  task automatic checkGates(input string req, input int st);
    checkEq(req, "gateHigh pwm=1", int'(gateHigh), expHigh(st));
    checkEq(req, "gateLow", int'(gateLow), expLow(st));
    pwmIn = 1'b0; #1;
    checkEq(req, "gateHigh pwm=0", int'(gateHigh), 0);
    checkEq(req, "gateLow pwm=0", int'(gateLow), expLow(st));
    pwmIn = 1'b1; #1;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    checkEq("R2", "gateHigh after reset", int'(gateHigh), 0);
    checkEq("R2", "gateLow after reset", int'(gateLow), 0);
    checkEq("R2", "commTrig after reset", int'(commTrig), 0);
    checkEq("R2", "hallError after reset", int'(hallError), 0);
    checkEq("R2", "edgeCount after reset", int'(edgeCount), 0);
  endtask

  task automatic testStartup();
    pulseTick();
    checkEq("R3", "state from startup code 5", int'(commState), 0);
    checkEq("R3", "no trigger at startup", int'(commTrig), 0);
    checkEq("R3", "no edge at startup", int'(edgeCount), 0);
    checkGates("R3", 0);
  endtask

  task automatic testDebounce();
    setHall(1);
    repeat (10) @(negedge clk);
    checkEq("R4", "no change without ticks", int'(commState), 0);
    ticks(LIMIT + 1);
    checkEq("R4", "not yet accepted at L+1 ticks", int'(commState), 0);
    checkEq("R4", "no trigger before acceptance", int'(commTrig), 0);
    pulseTick();
    expEdge++;
    checkEq("R4", "accepted at L+2 ticks", int'(commState), 1);
    checkEq("R6", "trigger on acceptance", int'(commTrig), 1);
    checkEq("R6", "edge counted", int'(edgeCount), expEdge);
    pulseTick();
    checkEq("R6", "trigger lasts one cycle", int'(commTrig), 0);
  endtask

  task automatic testGlitch();
    setHall(3); ticks(3);
    setHall(1); ticks(1);
    setHall(3); ticks(LIMIT);
    checkEq("R5", "count cleared by glitch, not yet accepted", int'(commState), 1);
    pulseTick();
    expEdge++;
    checkEq("R5", "buffer kept, accepted after L+1 ticks", int'(commState), 2);
    setHall(2); ticks(2);
    setHall(6); ticks(LIMIT + 1);
    checkEq("R5", "new sample restarts debounce", int'(commState), 2);
    pulseTick();
    expEdge++;
    checkEq("R5", "restarted candidate accepted", int'(commState), 4);
    checkEq("R6", "edge count after glitches", int'(edgeCount), expEdge);
  endtask

  task automatic testMapWalk();
    int seq [6] = '{5, 1, 3, 2, 6, 4};
    foreach (seq[k]) begin
      acceptCode(seq[k]);
      checkEq("R7", $sformatf("state for code %0d", seq[k]), int'(commState), expState(seq[k]));
      checkGates("R8", expState(seq[k]));
    end
    checkEq("R1", "A alone (code 4) selects state 5", int'(commState), 5);
    checkEq("R6", "edge count after walk", int'(edgeCount), expEdge);
  endtask

  task automatic testInvalid();
    acceptCode(7);
    checkEq("R9", "code 7 triggers", int'(commTrig), 1);
    checkEq("R9", "code 7 counts edge", int'(edgeCount), expEdge);
    checkEq("R9", "code 7 sets error", int'(hallError), 1);
    checkEq("R9", "code 7 keeps state", int'(commState), 5);
    checkGates("R9", 5);
    acceptCode(0);
    checkEq("R9", "code 0 sets error", int'(hallError), 1);
    checkEq("R9", "code 0 keeps state", int'(commState), 5);
    acceptCode(5);
    checkEq("R9", "valid code clears error", int'(hallError), 0);
    checkEq("R9", "valid code resolves state", int'(commState), 0);
  endtask

  task automatic quietSpan(input string what);
    int early = 0;
    for (int i = 0; i < STALL_SPAN - 1; i++) begin
      pulseTick();
      if (commTrig) early++;
    end
    checkEq("R10", {what, ": no trigger before span"}, early, 0);
    pulseTick();
    checkEq("R10", {what, ": trigger at span end"}, int'(commTrig), 1);
    checkEq("R10", {what, ": stall does not count edge"}, int'(edgeCount), expEdge);
  endtask

  task automatic testStall();
    quietSpan("first span");
    checkEq("R11", "stall keeps state", int'(commState), 0);
    checkGates("R11", 0);
    quietSpan("reloaded span");
    ticks(20);
    acceptCode(1);
    checkEq("R10", "edge inside span", int'(commState), 1);
    quietSpan("span after edge reload");
  endtask

  initial begin
    testReset();
    testStartup();
    testDebounce();
    testGlitch();
    testMapWalk();
    testInvalid();
    testStall();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule